// File: doc/BRIEF.md
# Display FIFO Port

This block sits between a host register bus and a graphics display device. The host sees a small register window. Writing a word to the data address places it, with no handshake, into a 16-word output FIFO. That FIFO drains to the display over a ready/valid word stream. One address is shared by two registers: the control register when written and the status register when read. The control register holds a single interrupt-enable bit.

The status word reports several things: the FIFO state, a busy line that comes straight from the display, a sticky overflow flag for words that were dropped, and the interrupt request in two forms. The raw request means "the FIFO appears empty". The gated request is that same condition masked by the enable. The interrupt output is a level that follows the gated request, so firmware can enable it, refill the FIFO when it drains, and clear the enable to silence it.

Top module: `disp_fifo_port`

## Requirements
- R1: While reset is held and after reset is released, the interrupt enable and the overflow flag are clear, the FIFO is empty (`out_valid` low) and `irq` is low, so a status read returns only bit 4 plus bit 5 if `dev_busy` is high.
- R2: A write to address 5 loads bit 3 of the written word into the interrupt enable and ignores every other bit of that word; writing zero clears the enable.
- R3: A write to address 6 pushes the word into the FIFO on that clock edge with no acknowledgement to the writer.
- R4: A read strobe at address 5 returns the status word on `reg_rdata` in the same cycle. Bit 3 is the enable, bit 4 is "FIFO empty", bit 5 is `dev_busy`, bit 6 is "FIFO full" (the data register cannot take a word), bit 7 is bit 3 AND bit 4, bit 8 is overflow, and all other bits are zero.
- R5: `irq` is a level equal to status bit 7: enable AND FIFO empty.
- R6: The FIFO holds 16 words. A data write while it holds 16 words is dropped and sets the overflow flag, which then stays set until reset.
- R7: The display side removes one word on each clock edge where `out_valid` and `out_ready` are both high. Words leave in the order they were written, and `out_data` shows the oldest word while `out_valid` is high.
- R8: `reg_rdata` is zero when there is no read strobe or when the address is not 5, and writes to addresses other than 5 and 6 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 36 | Write data |
| reg_rdata | output | 36 | Read data (status word or zero) |
| dev_busy | input | 1 | Busy flag from the display device |
| out_valid | output | 1 | FIFO has a word for the display |
| out_data | output | 36 | Oldest FIFO word |
| out_ready | input | 1 | Display accepts a word this cycle |
| irq | output | 1 | Level interrupt: enable AND FIFO empty |

## Verification
The FIFO path is tried in three ways: single words pushed and drained, a burst of distinct words drained back to back, and a fill past 16 entries. These show, in turn, whether ordering is kept, whether exactly one word is removed per handshake, and whether the dropped seventeenth word is both lost and flagged. The control path is driven with words that have bit 3 clear and all other bits set, and with words that have only bit 3 set. This shows that only bit 3 is decoded. The interrupt is watched across empty/non-empty transitions with the enable both on and off, which separates the raw request from the gated one. Stray writes and reads at unused addresses show that no state is touched and no stray data comes back.

// File: rtl/disp_fifo_pkg.sv
package disp_fifo_pkg;
  localparam int unsigned ADDR_BITS    = 3;
  localparam logic [ADDR_BITS-1:0] ADDR_CTRL_STAT = 3'd5;
  localparam logic [ADDR_BITS-1:0] ADDR_DATA      = 3'd6;

  localparam int unsigned ST_EN    = 3;
  localparam int unsigned ST_EMPTY = 4;
  localparam int unsigned ST_BUSY  = 5;
  localparam int unsigned ST_FULL  = 6;
  localparam int unsigned ST_IRQ   = 7;
  localparam int unsigned ST_OVF   = 8;
endpackage

// File: rtl/disp_rst_sync.sv
module disp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/disp_word_fifo.sv
module disp_word_fifo #(
  parameter int unsigned WIDTH = 36,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] fill
);
  localparam logic [PTR_W-1:0] LAST_PTR  = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_FILL = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] fill_q, fill_d;
  logic             do_push, do_pop;

  assign empty   = (fill_q == '0);
  assign full    = (fill_q == FULL_FILL);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    fill_d   = fill_q;
    if (do_push) wr_ptr_d = (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
    if (do_pop)  rd_ptr_d = (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   fill_d = fill_q + 1'b1;
      2'b01:   fill_d = fill_q - 1'b1;
      default: fill_d = fill_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      fill_q   <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= wdata;
  end

  assign rdata = mem[rd_ptr_q];
  assign fill  = fill_q;
endmodule

// File: rtl/disp_regs.sv
module disp_regs
  import disp_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              dev_busy,
  input  logic              fifo_empty,
  input  logic              fifo_full,
  output logic              push,
  output logic              irq
);
  logic en_q, en_d;
  logic ovf_q, ovf_d;
  logic ctrl_wr, data_wr, stat_rd;
  logic [DATA_W-1:0] status;

  assign ctrl_wr = reg_wr && (reg_addr == ADDR_W'(ADDR_CTRL_STAT));
  assign data_wr = reg_wr && (reg_addr == ADDR_W'(ADDR_DATA));
  assign stat_rd = reg_rd && (reg_addr == ADDR_W'(ADDR_CTRL_STAT));
  assign push    = data_wr;

  always_comb begin
    en_d  = en_q;
    ovf_d = ovf_q;
    if (ctrl_wr)              en_d  = reg_wdata[ST_EN];
    if (data_wr && fifo_full) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      ovf_q <= ovf_d;
    end
  end

  always_comb begin
    status           = '0;
    status[ST_EN]    = en_q;
    status[ST_EMPTY] = fifo_empty;
    status[ST_BUSY]  = dev_busy;
    status[ST_FULL]  = fifo_full;
    status[ST_IRQ]   = en_q & fifo_empty;
    status[ST_OVF]   = ovf_q;
  end

  assign reg_rdata = stat_rd ? status : '0;
  assign irq       = en_q & fifo_empty;
endmodule

// File: rtl/disp_fifo_port.sv
module disp_fifo_port #(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              dev_busy,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic              irq
);
  logic             rst_sn;
  logic             push;
  logic             fifo_empty, fifo_full;
  logic [CNT_W-1:0] fill;

  disp_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  disp_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sn),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .dev_busy   (dev_busy),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .push       (push),
    .irq        (irq)
  );

  disp_word_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_sn),
    .push  (push),
    .wdata (reg_wdata),
    .pop   (out_ready),
    .rdata (out_data),
    .empty (fifo_empty),
    .full  (fifo_full),
    .fill  (fill)
  );

  assign out_valid = !fifo_empty;
endmodule

// File: rtl/disp_fifo_port_chk.sv
module disp_fifo_port_chk #(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              dev_busy,
  input logic              out_valid,
  input logic              out_ready,
  input logic              irq,
  input logic [CNT_W-1:0]  fill
);
  logic ctrl_wr, data_wr, stat_rd, room;
  assign ctrl_wr = reg_wr && (reg_addr == ADDR_W'(5));
  assign data_wr = reg_wr && (reg_addr == ADDR_W'(6));
  assign stat_rd = reg_rd && (reg_addr == ADDR_W'(5));
  assign room    = (fill != CNT_W'(DEPTH));

  // R2: a control write with bit 3 clear leaves the interrupt low
  a_r2_ctrl_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !reg_wdata[3]) |=> !irq);

  // R5: an interrupt is only raised while the FIFO is empty
  a_r5_irq_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !out_valid);

  // R6: the FIFO never holds more than its depth
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH));

  // R6: overflow reported once stays reported
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && $past(stat_rd && reg_rdata[8])) |-> reg_rdata[8]);

  // R3: an accepted data write with no pop grows the fill by one
  a_r3_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && room && !(out_valid && out_ready)) |=> fill == $past(fill) + 1'b1);

  // R7: a handshake with no push removes exactly one word
  a_r7_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !data_wr) |=> fill == $past(fill) - 1'b1);

  // R8: no read data outside a status read
  a_r8_quiet_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |-> reg_rdata == '0);

  // R4: busy bit mirrors the display busy line
  a_r4_busy_bit: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |-> reg_rdata[5] == dev_busy);
endmodule

bind disp_fifo_port disp_fifo_port_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .dev_busy  (dev_busy),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .irq       (irq),
  .fill      (fill)
);

// File: tb/sim_disp_fifo_port.sv
module sim_disp_fifo_port;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 36;
  localparam int WATCHDOG_CYCLES = 20000;

  logic          clk;
  logic          rst_n;
  logic [2:0]    reg_addr;
  logic          reg_wr, reg_rd;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic          dev_busy;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          out_ready;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  disp_fifo_port u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dev_busy(dev_busy), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_status(bit en, bit empty, bit busy, bit full, bit ovf);
    logic [DW-1:0] s = '0;
    s[3] = en; s[4] = empty; s[5] = busy; s[6] = full; s[7] = en & empty; s[8] = ovf;
    return s;
  endfunction

  task automatic bus_write(logic [2:0] a, logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = '0;
  endtask

  task automatic bus_read(logic [2:0] a, output logic [DW-1:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    reg_rd = 1'b0; reg_addr = 3'd0;
  endtask

  task automatic pop_expect(string req, logic [DW-1:0] exp);
    @(negedge clk);
    #1;
    check(req, {35'd0, out_valid}, 36'd1);
    check(req, out_data, exp);
    out_ready = 1'b1;
    @(posedge clk);
    #1 out_ready = 1'b0;
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {35'd0, irq}, 36'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 valid after reset", {35'd0, out_valid}, 36'd0);
    check("R1 irq after reset", {35'd0, irq}, 36'd0);
    bus_read(3'd5, v);
    check("R1 status after reset", v, exp_status(0, 1, 0, 0, 0));
  endtask

  task automatic t_control;
    logic [DW-1:0] v;
    bus_write(3'd5, 36'h000000008);
    #1 check("R5 irq enabled and empty", {35'd0, irq}, 36'd1);
    bus_read(3'd5, v);
    check("R2 enable set", v, exp_status(1, 1, 0, 0, 0));
    bus_write(3'd5, 36'hFFFFFFFF7);
    #1 check("R2 other bits ignored, irq off", {35'd0, irq}, 36'd0);
    bus_read(3'd5, v);
    check("R2 enable cleared", v, exp_status(0, 1, 0, 0, 0));
    bus_write(3'd5, 36'h000000008);
    bus_write(3'd5, 36'h000000000);
    bus_read(3'd5, v);
    check("R2 zero write clears", v, exp_status(0, 1, 0, 0, 0));
  endtask

  task automatic t_irq_track;
    logic [DW-1:0] v;
    bus_write(3'd5, 36'h000000008);
    bus_write(3'd6, 36'hABCDE0123);
    #1 check("R5 irq drops when not empty", {35'd0, irq}, 36'd0);
    check("R3 word visible", out_data, 36'hABCDE0123);
    bus_read(3'd5, v);
    check("R4 raw low, gated low", v, exp_status(1, 0, 0, 0, 0));
    pop_expect("R7 single pop", 36'hABCDE0123);
    #1 check("R5 irq back after drain", {35'd0, irq}, 36'd1);
    bus_write(3'd5, 36'h0);
    #1 check("R5 irq off when disabled", {35'd0, irq}, 36'd0);
    bus_read(3'd5, v);
    check("R4 raw set, gated clear", v, exp_status(0, 1, 0, 0, 0));
  endtask

  task automatic t_burst;
    for (int i = 0; i < 5; i++) bus_write(3'd6, 36'h100000000 + DW'(i * 7));
    for (int i = 0; i < 5; i++) pop_expect("R7 burst order", 36'h100000000 + DW'(i * 7));
    @(negedge clk);
    check("R7 empty after burst", {35'd0, out_valid}, 36'd0);
  endtask

  task automatic t_back_to_back;
    bus_write(3'd6, 36'h111111111);
    bus_write(3'd6, 36'h222222222);
    bus_write(3'd6, 36'h333333333);
    @(negedge clk);
    out_ready = 1'b1;
    #1 check("R7 b2b first", out_data, 36'h111111111);
    @(negedge clk);
    #1 check("R7 b2b second", out_data, 36'h222222222);
    @(negedge clk);
    #1 check("R7 b2b third", out_data, 36'h333333333);
    @(negedge clk);
    out_ready = 1'b0;
    #1 check("R7 b2b drained", {35'd0, out_valid}, 36'd0);
  endtask

  task automatic t_full;
    logic [DW-1:0] v;
    for (int i = 0; i < 16; i++) bus_write(3'd6, 36'h200000000 + DW'(i));
    bus_read(3'd5, v);
    check("R6 full flag at 16", v, exp_status(0, 0, 0, 1, 0));
    bus_write(3'd6, 36'hDEADBEEF0);
    bus_read(3'd5, v);
    check("R6 overflow set", v, exp_status(0, 0, 0, 1, 1));
    for (int i = 0; i < 16; i++) pop_expect("R6 kept words", 36'h200000000 + DW'(i));
    @(negedge clk);
    check("R6 dropped word absent", {35'd0, out_valid}, 36'd0);
    bus_read(3'd5, v);
    check("R6 overflow sticky", v, exp_status(0, 1, 0, 0, 1));
  endtask

  task automatic t_busy;
    logic [DW-1:0] v;
    dev_busy = 1'b1;
    bus_read(3'd5, v);
    check("R4 busy mirrored", v, exp_status(0, 1, 1, 0, 1));
    dev_busy = 1'b0;
    bus_read(3'd5, v);
    check("R4 busy released", v, exp_status(0, 1, 0, 0, 1));
  endtask

  task automatic t_other_addr;
    logic [DW-1:0] v;
    bus_write(3'd2, 36'hFFFFFFFFF);
    bus_write(3'd7, 36'hFFFFFFFFF);
    #1 check("R8 no push from stray write", {35'd0, out_valid}, 36'd0);
    check("R8 no irq from stray write", {35'd0, irq}, 36'd0);
    bus_read(3'd6, v);
    check("R8 read of data address", v, 36'd0);
    bus_read(3'd0, v);
    check("R8 read of unused address", v, 36'd0);
    @(negedge clk);
    reg_addr = 3'd5;
    #1 check("R8 no strobe no data", reg_rdata, 36'd0);
    reg_addr = 3'd0;
    bus_read(3'd5, v);
    check("R8 state untouched", v, exp_status(0, 1, 0, 0, 1));
  endtask

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_wdata = '0; dev_busy = 1'b0; out_ready = 1'b0;
    t_reset();
    t_control();
    t_irq_track();
    t_burst();
    t_back_to_back();
    t_full();
    t_busy();
    t_other_addr();
    t_reset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule